// File: doc/BRIEF.md
# Suspend Modulation Duty Timer

This block slows a processor down by switching an active-low suspend output on and off. While the output is low the processor idles. While it is high the processor runs. A programmable ON count sets how long the output stays low and a programmable OFF count sets how long it stays high. Both counts are 8-bit values measured in 32 µs ticks. A prescaler makes the tick from the block clock, with its divide value given as a parameter. The effective processing rate is the full rate times OFF / (OFF + ON).

Firmware sets up the block through a small byte-wide register port with a registered read path:

| Register | Offset | Content |
|---|---|---|
| OFF count | 0x94 | 8-bit OFF count |
| ON count | 0x95 | 8-bit ON count |
| Configuration | 0x96 | bit 0 is the modulation enable |
| Power-management enable | 0x80 | bit 3 enables interrupt speedup, bit 4 enables video speedup |
| Interrupt speedup duration | 0x8C | duration in 1 ms units |
| Video speedup duration | 0x8D | duration in 1 ms units |

When interrupt or video activity is reported and the matching speedup is enabled, the output is released at once. It stays released for that speedup's duration, counted in 1 ms units. Each 1 ms unit is built from MS_TICKS ticks. When the activity is over, modulation resumes.

New ON and OFF values are picked up only when a full ON+OFF period ends, so a period that is already running is never cut short.

Top module: `susp_duty_timer`

## Requirements
- R1: After reset, susp_n is high (1) and every register at 0x80, 0x8C, 0x8D, 0x94, 0x95 and 0x96 reads back as 0.
- R2: A write with wr_en at one of the offsets 0x80, 0x8C, 0x8D, 0x94, 0x95 or 0x96 stores wr_data there. rd_data shows the register selected by rd_addr one clock after rd_addr is sampled. Any other offset reads as 0, and writes to it are ignored.
- R3: With the enable (bit 0 of 0x96) set and both counts nonzero, susp_n repeats a pattern. It is low for ON*TICK_DIV clock cycles, then high for OFF*TICK_DIV clock cycles.
- R4: When the enable bit is clear, susp_n is high no later than the second clock edge after the write that cleared it, and it stays high.
- R5: An ON count of 0 keeps susp_n high, whatever the OFF count is.
- R6: An OFF count of 0 with a nonzero ON count keeps susp_n low without a break while no speedup is active.
- R7: ON and OFF values written during a period take effect only from the next period. The period in progress keeps the values it started with.
- R8: An irq_evt pulse with bit 3 of 0x80 set drives susp_n high at the clock edge that samples it. susp_n then stays high for D*MS_TICKS ticks, within one tick, where D is the value at 0x8C.
- R9: A vid_evt pulse with bit 4 of 0x80 set drives susp_n high at the clock edge that samples it. susp_n then stays high for D*MS_TICKS ticks, within one tick, where D is the value at 0x8D.
- R10: An irq_evt or vid_evt pulse whose speedup enable bit is clear has no effect on susp_n.
- R11: A new event that arrives while its speedup timer is running reloads that timer with the full duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 8 | Registered read data |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
The assertions assume that irq_evt, vid_evt and the write port are synchronous to clk. They also assume that wr_addr and wr_data are valid in every cycle in which wr_en is high, since a write is checked against the data that was present at the sampling edge. The stimulus meets this by changing every input only on the falling clock edge, by holding each event and each write strobe for exactly one cycle, and by always applying reset from time zero.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int REG_W = 8;

  localparam logic [7:0] OFS_PMEN   = 8'h80;
  localparam logic [7:0] OFS_IRQDUR = 8'h8C;
  localparam logic [7:0] OFS_VIDDUR = 8'h8D;
  localparam logic [7:0] OFS_OFFCNT = 8'h94;
  localparam logic [7:0] OFS_ONCNT  = 8'h95;
  localparam logic [7:0] OFS_CFG    = 8'h96;

  localparam int BIT_MODEN = 0;
  localparam int BIT_IRQSP = 3;
  localparam int BIT_VIDSP = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_ON, PH_OFF} phase_t;

  typedef struct packed {
    logic [REG_W-1:0] off_cnt;
    logic [REG_W-1:0] on_cnt;
    logic [REG_W-1:0] cfg;
    logic [REG_W-1:0] pmen;
    logic [REG_W-1:0] irq_dur;
    logic [REG_W-1:0] vid_dur;
  } regs_t;
endpackage

// File: rtl/sdt_regs.sv
module sdt_regs
  import sdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [7:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  output regs_t            regs
);
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_OFFCNT: regs.off_cnt <= wr_data;
        OFS_ONCNT:  regs.on_cnt  <= wr_data;
        OFS_CFG:    regs.cfg     <= wr_data;
        OFS_PMEN:   regs.pmen    <= wr_data;
        OFS_IRQDUR: regs.irq_dur <= wr_data;
        OFS_VIDDUR: regs.vid_dur <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      OFS_OFFCNT: rd_mux = regs.off_cnt;
      OFS_ONCNT:  rd_mux = regs.on_cnt;
      OFS_CFG:    rd_mux = regs.cfg;
      OFS_PMEN:   rd_mux = regs.pmen;
      OFS_IRQDUR: rd_mux = regs.irq_dur;
      OFS_VIDDUR: rd_mux = regs.vid_dur;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/sdt_prescale.sv
module sdt_prescale #(
  parameter int TICK_DIV = 4000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdt_speedup.sv
module sdt_speedup
  import sdt_pkg::*;
#(
  parameter int MS_TICKS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             evt,
  input  logic             allow,
  input  logic [REG_W-1:0] dur,
  output logic             busy
);
  localparam int SW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(MS_TICKS - 1);

  logic [REG_W-1:0] remain;
  logic [SW-1:0]    sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      sub    <= '0;
    end else if (evt && allow) begin
      remain <= dur;
      sub    <= '0;
    end else if (tick && (remain != '0)) begin
      if (sub == SUB_LAST) begin
        sub    <= '0;
        remain <= remain - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/sdt_modulator.sv
module sdt_modulator
  import sdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [REG_W-1:0] on_val,
  input  logic [REG_W-1:0] off_val,
  output logic             assert_req
);
  phase_t           phase, ld_phase;
  logic [REG_W-1:0] left, ld_left;
  logic [REG_W-1:0] off_snap;

  // values a fresh period starts with
  always_comb begin
    if (on_val != '0) begin
      ld_phase = PH_ON;
      ld_left  = on_val;
    end else if (off_val != '0) begin
      ld_phase = PH_OFF;
      ld_left  = off_val;
    end else begin
      ld_phase = PH_IDLE;
      ld_left  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      left     <= '0;
      off_snap <= '0;
    end else if (!en) begin
      phase <= PH_IDLE;
      left  <= '0;
    end else if (tick) begin
      if (left > 8'd1) begin
        left <= left - 1'b1;
      end else if (phase == PH_ON && off_snap != '0) begin
        phase <= PH_OFF;
        left  <= off_snap;
      end else begin
        phase    <= ld_phase;
        left     <= ld_left;
        off_snap <= off_val;
      end
    end
  end

  assign assert_req = (phase == PH_ON);
endmodule

// File: rtl/susp_duty_timer.sv
module susp_duty_timer
  import sdt_pkg::*;
#(
  parameter int TICK_DIV = 4000,
  parameter int MS_TICKS = 31
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       irq_evt,
  input  logic       vid_evt,
  output logic       susp_n
);
  regs_t            regs;
  logic             tick;
  logic             mod_en, irq_sp_en, vid_sp_en;
  logic [REG_W-1:0] on_val, irq_dur;
  logic             irq_busy, vid_busy, mod_assert;
  logic             hold_off;

  sdt_regs regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .regs(regs)
  );

  assign mod_en    = regs.cfg[BIT_MODEN];
  assign irq_sp_en = regs.pmen[BIT_IRQSP];
  assign vid_sp_en = regs.pmen[BIT_VIDSP];
  assign on_val    = regs.on_cnt;
  assign irq_dur   = regs.irq_dur;

  sdt_prescale #(.TICK_DIV(TICK_DIV)) pre_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sdt_speedup #(.MS_TICKS(MS_TICKS)) irq_sp_i (
    .clk(clk), .rst(rst), .tick(tick), .evt(irq_evt), .allow(irq_sp_en),
    .dur(regs.irq_dur), .busy(irq_busy)
  );

  sdt_speedup #(.MS_TICKS(MS_TICKS)) vid_sp_i (
    .clk(clk), .rst(rst), .tick(tick), .evt(vid_evt), .allow(vid_sp_en),
    .dur(regs.vid_dur), .busy(vid_busy)
  );

  sdt_modulator mod_i (
    .clk(clk), .rst(rst), .tick(tick), .en(mod_en),
    .on_val(regs.on_cnt), .off_val(regs.off_cnt), .assert_req(mod_assert)
  );

  assign hold_off = irq_busy || vid_busy ||
                    (irq_evt && irq_sp_en) || (vid_evt && vid_sp_en);

  always_ff @(posedge clk) begin
    if (rst) susp_n <= 1'b1;
    else     susp_n <= !(mod_assert && mod_en && !hold_off);
  end
endmodule

// File: rtl/sdt_checker.sv
module sdt_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       irq_evt,
  input logic       vid_evt,
  input logic       susp_n,
  input logic       mod_en,
  input logic       irq_sp_en,
  input logic       vid_sp_en,
  input logic [7:0] on_val,
  input logic [7:0] irq_dur,
  input logic       irq_busy
);
  AST_ON_WRITE_STORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h95) |=> (on_val == $past(wr_data))); // R2

  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> susp_n); // R4

  AST_IRQ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && irq_sp_en) |=> susp_n); // R8

  AST_VID_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (vid_evt && vid_sp_en) |=> susp_n); // R9

  AST_IRQ_TIMER_LOADED: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && irq_sp_en && irq_dur != 8'd0) |=> irq_busy); // R11
endmodule

bind susp_duty_timer sdt_checker chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n), .mod_en(mod_en),
  .irq_sp_en(irq_sp_en), .vid_sp_en(vid_sp_en), .on_val(on_val),
  .irq_dur(irq_dur), .irq_busy(irq_busy)
);

// File: tb/susp_duty_timer_tb_top.sv
module susp_duty_timer_tb_top;
  localparam int TD = 4;
  localparam int MT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_evt = 1'b0, vid_evt = 1'b0;
  logic       susp_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { bit lvl; int width; string req; } seg_t;
  seg_t exp_q[$];
  bit armed = 0;

  always #4 clk = ~clk;

  susp_duty_timer #(.TICK_DIV(TD), .MS_TICKS(MT)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_evt(irq_evt), .vid_evt(vid_evt),
    .susp_n(susp_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input bit is_vid);
    @(negedge clk);
    if (is_vid) vid_evt = 1'b1; else irq_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0; vid_evt = 1'b0;
  endtask

  task automatic wait_low(input string req);
    int n = 0;
    while (susp_n !== 1'b0 && n < 500) begin @(negedge clk); n++; end
    chk(susp_n === 1'b0, req, susp_n, 0);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin @(posedge clk); n++; end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    @(posedge clk);
    armed = 0;
  endtask

  // driver: pushes the expected segments, then lets modulation run
  task automatic run_sb(input int on, input int off, input int n, input string req);
    wr(8'h96, 8'h00);
    wr(8'h95, 8'(on));
    wr(8'h94, 8'(off));
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{1'b0, on * TD, req});
      exp_q.push_back('{1'b1, off * TD, req});
    end
    @(posedge clk);
    armed = 1;
    wr(8'h96, 8'h01);
    drain(req);
    wr(8'h96, 8'h00);
  endtask

  // monitor: measures the finished low and high segments and compares them
  bit prev_lvl = 1'b1;
  bit started = 0;
  int seg_len = 0;
  always @(negedge clk) begin
    if (!armed) begin
      started  <= 0;
      seg_len  <= 0;
      prev_lvl <= susp_n;
    end else begin
      if (susp_n != prev_lvl) begin
        if (started && exp_q.size() > 0) begin
          seg_t e;
          e = exp_q.pop_front();
          chk(e.lvl == prev_lvl, {e.req, " level"}, prev_lvl, e.lvl);
          chk(e.width == seg_len, {e.req, " width"}, seg_len, e.width);
        end
        if (!susp_n) started <= 1;
        seg_len <= 1;
      end else begin
        seg_len <= seg_len + 1;
      end
      prev_lvl <= susp_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(susp_n === 1'b1, "R1 susp_n", susp_n, 1);
    rd(8'h80, d); chk(d == 0, "R1 0x80", d, 0);
    rd(8'h8C, d); chk(d == 0, "R1 0x8C", d, 0);
    rd(8'h8D, d); chk(d == 0, "R1 0x8D", d, 0);
    rd(8'h94, d); chk(d == 0, "R1 0x94", d, 0);
    rd(8'h95, d); chk(d == 0, "R1 0x95", d, 0);
    rd(8'h96, d); chk(d == 0, "R1 0x96", d, 0);

    // R2 register map
    wr(8'h94, 8'h5A); wr(8'h95, 8'hA5); wr(8'h8C, 8'h11); wr(8'h8D, 8'h22);
    wr(8'h80, 8'h60); wr(8'h96, 8'h80);
    wr(8'h90, 8'hFF);
    rd(8'h94, d); chk(d == 8'h5A, "R2 0x94", d, 8'h5A);
    rd(8'h95, d); chk(d == 8'hA5, "R2 0x95", d, 8'hA5);
    rd(8'h8C, d); chk(d == 8'h11, "R2 0x8C", d, 8'h11);
    rd(8'h8D, d); chk(d == 8'h22, "R2 0x8D", d, 8'h22);
    rd(8'h80, d); chk(d == 8'h60, "R2 0x80", d, 8'h60);
    rd(8'h96, d); chk(d == 8'h80, "R2 0x96", d, 8'h80);
    rd(8'h90, d); chk(d == 8'h00, "R2 unmapped", d, 0);
    chk(susp_n === 1'b1, "R4 enable bit clear", susp_n, 1);
    wr(8'h80, 8'h00); wr(8'h96, 8'h00);

    // R3 duty patterns
    run_sb(3, 5, 3, "R3 3/5");
    run_sb(1, 1, 4, "R3 1/1");
    run_sb(7, 2, 2, "R3 7/2");

    // R7 change mid-period
    wr(8'h95, 8'd3); wr(8'h94, 8'd3);
    exp_q.push_back('{1'b0, 3 * TD, "R7 old on"});
    exp_q.push_back('{1'b1, 3 * TD, "R7 old off"});
    exp_q.push_back('{1'b0, 6 * TD, "R7 new on"});
    exp_q.push_back('{1'b1, 2 * TD, "R7 new off"});
    @(posedge clk);
    armed = 1;
    wr(8'h96, 8'h01);
    wait_low("R7 start");
    wr(8'h95, 8'd6);
    wr(8'h94, 8'd2);
    drain("R7");
    wr(8'h96, 8'h00);

    // R6 OFF zero: continuously asserted
    wr(8'h95, 8'd4); wr(8'h94, 8'd0); wr(8'h96, 8'h01);
    wait_low("R6 start");
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (susp_n) cnt++; end
    chk(cnt == 0, "R6 high samples", cnt, 0);

    // R4 disable releases
    wr(8'h96, 8'h00);
    @(negedge clk);
    chk(susp_n === 1'b1, "R4 released", susp_n, 1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!susp_n) cnt++; end
    chk(cnt == 0, "R4 stays high", cnt, 0);

    // R5 ON zero: never asserted
    wr(8'h95, 8'd0); wr(8'h94, 8'd3); wr(8'h96, 8'h01);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!susp_n) cnt++; end
    chk(cnt == 0, "R5 on=0 off=3", cnt, 0);
    wr(8'h94, 8'd0);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (!susp_n) cnt++; end
    chk(cnt == 0, "R5 on=0 off=0", cnt, 0);

    // R10 speedup disabled: events ignored
    wr(8'h8C, 8'd2); wr(8'h8D, 8'd3); wr(8'h80, 8'h00);
    wr(8'h95, 8'd5); wr(8'h94, 8'd0);
    wait_low("R10 start");
    pulse(0);
    chk(susp_n === 1'b0, "R10 irq ignored", susp_n, 0);
    pulse(1);
    chk(susp_n === 1'b0, "R10 vid ignored", susp_n, 0);
    repeat (10) @(negedge clk);
    chk(susp_n === 1'b0, "R10 still low", susp_n, 0);

    // R8 interrupt speedup, D=2 -> 8 ticks = 32 cycles
    wr(8'h80, 8'h08);
    pulse(0);
    chk(susp_n === 1'b1, "R8 immediate", susp_n, 1);
    repeat (24) @(negedge clk);
    chk(susp_n === 1'b1, "R8 held", susp_n, 1);
    repeat (15) @(negedge clk);
    chk(susp_n === 1'b0, "R8 resumed", susp_n, 0);

    // R11 retrigger reloads
    pulse(0);
    repeat (19) @(negedge clk);
    pulse(0);
    repeat (24) @(negedge clk);
    chk(susp_n === 1'b1, "R11 reloaded", susp_n, 1);
    repeat (15) @(negedge clk);
    chk(susp_n === 1'b0, "R11 resumed", susp_n, 0);

    // R9 video speedup, D=3 -> 12 ticks = 48 cycles
    wr(8'h80, 8'h10);
    pulse(1);
    chk(susp_n === 1'b1, "R9 immediate", susp_n, 1);
    repeat (40) @(negedge clk);
    chk(susp_n === 1'b1, "R9 held", susp_n, 1);
    repeat (19) @(negedge clk);
    chk(susp_n === 1'b0, "R9 resumed", susp_n, 0);
    pulse(0);
    chk(susp_n === 1'b0, "R10 irq bit clear", susp_n, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule